// File: doc/BRIEF.md
# SD Host Command Issue Register

This block is the command word and launch handshake of an SD/MMC host controller. Software first writes a 32-bit argument, then a command word. The command word packs a command index and a set of flags: response expected, long response, response CRC check, data phase, write direction, stream mode, automatic stop, wait for the previous transfer, initialisation sequence and clock update. The top bit of the word is a start bit. The block splits the stored word into separate control outputs for the command and data engines. It offers a started command to the command engine through a valid/ready pair.

While a command is pending, the start bit reads back as 1. It drops by itself once the command engine accepts the command, or once a clock-update command has finished. Software therefore polls one bit to learn when the register is free again.

A command that asks to wait for the previous transfer is held back while the card signals busy on its data line. That busy input passes through a parameterised synchroniser first. A clock-update command never reaches the command engine. After a fixed number of unblocked cycles it produces a single pulse that tells the clock generator to load its new enable and divider settings.

Top module: `sdcmd_issue_reg`

## Requirements
- R1: After reset, the command readback, the argument readback, `launch_valid` and `clk_apply` are all 0.
- R2: The stored command word drives the decoded outputs, whether or not its start bit was set. The field positions are:
  - bits 5:0: index
  - bit 6: response expected
  - bit 7: long response
  - bit 8: response CRC check
  - bit 9: data phase
  - bit 10: write
  - bit 11: stream
  - bit 12: automatic stop
  - bit 13: wait for the previous transfer
  - bit 15: initialisation sequence
  - bit 21: clock update
  - bit 31: start
- R3: The command readback returns the defined fields of the stored word. Bits 14, 20:16 and 30:22 always read 0. Bit 31 reads 1 exactly while a command is pending.
- R4: A command write with bit 31 at 0 updates the stored fields but launches nothing: neither `launch_valid` nor `clk_apply` rises.
- R5: A started bus command (bit 21 at 0) raises `launch_valid` in the cycle after the write, unless R7 blocks it. `launch_valid` and the decoded outputs stay steady until `launch_ready` is seen. The start bit reads 0 from the cycle after acceptance.
- R6: While the start bit reads 1, writes to the command register and to the argument register are ignored.
- R7: A pending command with bit 13 set is held while the synchronised card-busy flag is 1. `card_busy` reaches the interlock through BUSY_SYNC flip-flops (default 2).
- R8: A pending command with bit 13 clear is not held by card busy.
- R9: A started clock-update command never raises `launch_valid`. It raises `clk_apply` for exactly one cycle, UPD_CYCLES unblocked cycles after the write (default 3). Its start bit reads 0 from the following cycle.
- R10: A clock-update command with bit 13 set is also held while card busy is seen. Its cycle count starts only once the hold is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arg_wr_en | input | 1 | Write strobe for the argument register |
| cmd_wr_en | input | 1 | Write strobe for the command register |
| wr_data | input | 32 | Write data shared by both registers |
| arg_rdata | output | 32 | Argument register readback |
| cmd_rdata | output | 32 | Command register readback, with the start bit |
| card_busy | input | 1 | Card holds its data line low (asynchronous) |
| launch_valid | output | 1 | A bus command is offered to the command engine |
| launch_ready | input | 1 | The command engine takes the offered command |
| cmd_index | output | 6 | Decoded command index |
| cmd_arg | output | 32 | Argument presented with the command |
| resp_expect | output | 1 | A response is expected |
| resp_long | output | 1 | The response is 136 bits long |
| resp_crc_chk | output | 1 | Check the response CRC |
| data_phase | output | 1 | A data transfer follows |
| data_write | output | 1 | Data direction is host to card |
| stream_mode | output | 1 | Stream transfer instead of blocks |
| auto_stop | output | 1 | Send a stop command after the data |
| send_init | output | 1 | Send the initialisation sequence first |
| clk_apply | output | 1 | One-cycle pulse: load the new clock settings |

## Verification
A start bit stuck high would show at once as a command readback that never drops bit 31 after `launch_ready` or after a clock-update pulse. A start bit cleared early would drop `launch_valid` before any acceptance. A missing write guard would show in the next readback as a changed index or argument while a command is still pending. A wrong synchroniser depth, or a busy interlock wired to the wrong flag, moves the cycle in which `launch_valid` or `clk_apply` appears after busy is released, so the bench samples those outputs in each exact cycle. A clock-update counter that is off by one shifts the single `clk_apply` pulse by one cycle.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

    localparam int CMD_W = 32;
    localparam int ARG_W = 32;
    localparam int IDX_W = 6;

    // Layout of the command word; bit positions are software visible.
    typedef struct packed {
        logic             start;      // 31
        logic [8:0]       rsvd_hi;    // 30:22
        logic             clk_upd;    // 21
        logic [4:0]       rsvd_mid;   // 20:16
        logic             send_init;  // 15
        logic             rsvd_lo;    // 14
        logic             wait_prev;  // 13
        logic             auto_stop;  // 12
        logic             stream;     // 11
        logic             data_wr;    // 10
        logic             data_en;    // 9
        logic             resp_crc;   // 8
        logic             resp_long;  // 7
        logic             resp_en;    // 6
        logic [IDX_W-1:0] idx;        // 5:0
    } cmd_word_t;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_HELD,
        PH_OFFER,
        PH_CLKUPD
    } issue_phase_t;

    // Force reserved fields to zero so they never read back as set.
    function automatic cmd_word_t scrub(input cmd_word_t w);
        cmd_word_t r;
        r          = w;
        r.rsvd_hi  = '0;
        r.rsvd_mid = '0;
        r.rsvd_lo  = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/sdcmd_busy_sync.sv
module sdcmd_busy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic busy_in,
    output logic busy_out
);

    generate
        if (STAGES == 0) begin : g_direct
            assign busy_out = busy_in;
        end else begin : g_sync
            logic [STAGES-1:0] sr;
            always_ff @(posedge clk) begin
                if (rst) begin
                    sr <= '0;
                end else begin
                    sr[0] <= busy_in;
                    for (int i = 1; i < STAGES; i++) begin
                        sr[i] <= sr[i-1];
                    end
                end
            end
            assign busy_out = sr[STAGES-1];
        end
    endgenerate

endmodule

// File: rtl/sdcmd_launch_ctl.sv
module sdcmd_launch_ctl
    import sdcmd_pkg::*;
#(
    parameter int UPD_CYCLES = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic pending,
    input  logic take,
    input  logic is_upd,
    input  logic wait_prev,
    input  logic busy_s,
    input  logic launch_ready,
    output logic launch_valid,
    output logic clk_apply,
    output logic clear_load
);

    localparam int CNT_W = (UPD_CYCLES < 2) ? 1 : $clog2(UPD_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(UPD_CYCLES - 1);

    issue_phase_t     phase;
    logic [CNT_W-1:0] cnt;
    logic             at_last;

    always_comb begin
        if (!pending) begin
            phase = PH_IDLE;
        end else if (wait_prev && busy_s) begin
            phase = PH_HELD;
        end else if (is_upd) begin
            phase = PH_CLKUPD;
        end else begin
            phase = PH_OFFER;
        end
    end

    assign at_last      = (cnt == LAST);
    assign launch_valid = (phase == PH_OFFER);
    assign clk_apply    = (phase == PH_CLKUPD) && at_last;
    assign clear_load   = (launch_valid && launch_ready) || clk_apply;

    // Counts only unblocked clock-update cycles; restarts on each accepted write.
    always_ff @(posedge clk) begin
        if (rst || take) begin
            cnt <= '0;
        end else if ((phase == PH_CLKUPD) && !at_last) begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);                                                     // R9
    AST_APPLY_NOT_LAUNCH: assert property (@(posedge clk) disable iff (rst)
        clk_apply |=> !clk_apply);                                        // R9

endmodule

// File: rtl/sdcmd_issue_reg.sv
module sdcmd_issue_reg
    import sdcmd_pkg::*;
#(
    parameter int BUSY_SYNC  = 2,
    parameter int UPD_CYCLES = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arg_wr_en,
    input  logic             cmd_wr_en,
    input  logic [CMD_W-1:0] wr_data,
    output logic [ARG_W-1:0] arg_rdata,
    output logic [CMD_W-1:0] cmd_rdata,
    input  logic             card_busy,
    output logic             launch_valid,
    input  logic             launch_ready,
    output logic [IDX_W-1:0] cmd_index,
    output logic [ARG_W-1:0] cmd_arg,
    output logic             resp_expect,
    output logic             resp_long,
    output logic             resp_crc_chk,
    output logic             data_phase,
    output logic             data_write,
    output logic             stream_mode,
    output logic             auto_stop,
    output logic             send_init,
    output logic             clk_apply
);

    cmd_word_t        word_q;
    logic [ARG_W-1:0] arg_q;
    logic             cmd_take;
    logic             arg_take;
    logic             busy_s;
    logic             clear_load;

    assign cmd_take = cmd_wr_en && !word_q.start;
    assign arg_take = arg_wr_en && !word_q.start;

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
        end else if (cmd_take) begin
            word_q <= scrub(cmd_word_t'(wr_data));
        end else if (clear_load) begin
            word_q.start <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            arg_q <= '0;
        end else if (arg_take) begin
            arg_q <= wr_data[ARG_W-1:0];
        end
    end

    sdcmd_busy_sync #(.STAGES(BUSY_SYNC)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .busy_in  (card_busy),
        .busy_out (busy_s)
    );

    sdcmd_launch_ctl #(.UPD_CYCLES(UPD_CYCLES)) u_ctl (
        .clk          (clk),
        .rst          (rst),
        .pending      (word_q.start),
        .take         (cmd_take),
        .is_upd       (word_q.clk_upd),
        .wait_prev    (word_q.wait_prev),
        .busy_s       (busy_s),
        .launch_ready (launch_ready),
        .launch_valid (launch_valid),
        .clk_apply    (clk_apply),
        .clear_load   (clear_load)
    );

    assign cmd_rdata    = word_q;
    assign arg_rdata    = arg_q;
    assign cmd_arg      = arg_q;
    assign cmd_index    = word_q.idx;
    assign resp_expect  = word_q.resp_en;
    assign resp_long    = word_q.resp_long;
    assign resp_crc_chk = word_q.resp_crc;
    assign data_phase   = word_q.data_en;
    assign data_write   = word_q.data_wr;
    assign stream_mode  = word_q.stream;
    assign auto_stop    = word_q.auto_stop;
    assign send_init    = word_q.send_init;

    AST_LOAD_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (word_q.start && !launch_ready && !clk_apply) |=> word_q.start);  // R5
    AST_CLEAR_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $fell(word_q.start) |-> $past((launch_valid && launch_ready) || clk_apply)); // R5
    AST_WORD_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (word_q.start && $past(word_q.start)) |-> $stable(word_q[CMD_W-2:0])); // R6
    AST_ARG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (word_q.start && $past(word_q.start)) |-> $stable(arg_q));        // R6
    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (busy_s && word_q.wait_prev) |-> (!launch_valid && !clk_apply));  // R7
    AST_UPD_SILENT: assert property (@(posedge clk) disable iff (rst)
        word_q.clk_upd |-> !launch_valid);                                // R9

endmodule

// File: tb/tb_sdcmd_issue_reg.sv
module tb_sdcmd_issue_reg;

    localparam int SYNC = 2;
    localparam int UPD  = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        arg_wr_en = 1'b0;
    logic        cmd_wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] arg_rdata;
    logic [31:0] cmd_rdata;
    logic        card_busy = 1'b0;
    logic        launch_valid;
    logic        launch_ready = 1'b0;
    logic [5:0]  cmd_index;
    logic [31:0] cmd_arg;
    logic        resp_expect, resp_long, resp_crc_chk, data_phase;
    logic        data_write, stream_mode, auto_stop, send_init, clk_apply;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #5 clk = ~clk;

    sdcmd_issue_reg #(.BUSY_SYNC(SYNC), .UPD_CYCLES(UPD)) dut (
        .clk(clk), .rst(rst), .arg_wr_en(arg_wr_en), .cmd_wr_en(cmd_wr_en),
        .wr_data(wr_data), .arg_rdata(arg_rdata), .cmd_rdata(cmd_rdata),
        .card_busy(card_busy), .launch_valid(launch_valid),
        .launch_ready(launch_ready), .cmd_index(cmd_index), .cmd_arg(cmd_arg),
        .resp_expect(resp_expect), .resp_long(resp_long),
        .resp_crc_chk(resp_crc_chk), .data_phase(data_phase),
        .data_write(data_write), .stream_mode(stream_mode),
        .auto_stop(auto_stop), .send_init(send_init), .clk_apply(clk_apply)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 50000) begin
            fails++;
            $display("FAIL watchdog: cycles=%0d expected below %0d", cyc, 50000);
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr_cmd(input logic [31:0] d);
        @(negedge clk);
        cmd_wr_en = 1'b1;
        wr_data   = d;
        @(negedge clk);
        cmd_wr_en = 1'b0;
    endtask

    task automatic wr_arg(input logic [31:0] d);
        @(negedge clk);
        arg_wr_en = 1'b1;
        wr_data   = d;
        @(negedge clk);
        arg_wr_en = 1'b0;
    endtask

    // Expected readback: defined fields only (bits 13:0, 15, 21, 31).
    function automatic logic [31:0] rb(input logic [31:0] w);
        return w & 32'h8020_BFFF;
    endfunction

    function automatic logic [7:0] flags_of(input logic [31:0] w);
        return {w[15], w[12], w[11], w[10], w[9], w[8], w[7], w[6]};
    endfunction

    function automatic logic [7:0] flags_out();
        return {send_init, auto_stop, stream_mode, data_write, data_phase,
                resp_crc_chk, resp_long, resp_expect};
    endfunction

    task automatic t_reset();
        chk("R1 cmd_rdata", cmd_rdata, 32'h0);
        chk("R1 arg_rdata", arg_rdata, 32'h0);
        chk("R1 launch_valid", {31'h0, launch_valid}, 32'h0);
        chk("R1 clk_apply", {31'h0, clk_apply}, 32'h0);
    endtask

    task automatic t_decode(input logic [31:0] w);
        wr_cmd(w);
        chk("R3 readback", cmd_rdata, rb(w));
        chk("R2 index", {26'h0, cmd_index}, {26'h0, w[5:0]});
        chk("R2 flags", {24'h0, flags_out()}, {24'h0, flags_of(w)});
        for (int k = 0; k < 2; k++) begin
            chk("R4 no launch", {31'h0, launch_valid}, 32'h0);
            chk("R4 no apply", {31'h0, clk_apply}, 32'h0);
            step();
        end
    endtask

    task automatic t_bus_launch();
        launch_ready = 1'b0;
        wr_cmd(32'h8000_1751);
        chk("R5 valid next cycle", {31'h0, launch_valid}, 32'h1);
        chk("R3 start reads 1", cmd_rdata, 32'h8000_1751);
        for (int k = 0; k < 3; k++) begin
            step();
            chk("R5 valid held", {31'h0, launch_valid}, 32'h1);
            chk("R5 index steady", {26'h0, cmd_index}, 32'h11);
        end
        launch_ready = 1'b1;
        step();
        launch_ready = 1'b0;
        chk("R5 start cleared", cmd_rdata, 32'h0000_1751);
        chk("R5 valid dropped", {31'h0, launch_valid}, 32'h0);
    endtask

    task automatic t_ignore();
        launch_ready = 1'b0;
        wr_arg(32'hA5A5_0001);
        wr_cmd(32'h8000_0048);
        wr_cmd(32'h8000_003F);
        wr_arg(32'hFFFF_0000);
        chk("R6 cmd unchanged", cmd_rdata, 32'h8000_0048);
        chk("R6 index unchanged", {26'h0, cmd_index}, 32'h8);
        chk("R6 arg unchanged", cmd_arg, 32'hA5A5_0001);
        launch_ready = 1'b1;
        step();
        launch_ready = 1'b0;
        chk("R5 cleared after accept", cmd_rdata, 32'h0000_0048);
        wr_cmd(32'h0000_0003);
        chk("R6 write taken when idle", cmd_rdata, 32'h0000_0003);
    endtask

    task automatic t_busy_wait();
        card_busy = 1'b1;
        launch_ready = 1'b0;
        for (int k = 0; k < SYNC + 1; k++) step();
        wr_arg(32'h1234_5678);
        wr_cmd(32'h8000_2052);
        for (int k = 0; k < 4; k++) begin
            chk("R7 held while busy", {31'h0, launch_valid}, 32'h0);
            chk("R7 start stays", {31'h0, cmd_rdata[31]}, 32'h1);
            step();
        end
        card_busy = 1'b0;
        for (int k = 1; k <= SYNC; k++) begin
            step();
            chk("R7 release after sync", {31'h0, launch_valid}, {31'h0, k == SYNC});
        end
        chk("R7 arg presented", cmd_arg, 32'h1234_5678);
        launch_ready = 1'b1;
        step();
        launch_ready = 1'b0;
        chk("R7 start cleared", {31'h0, cmd_rdata[31]}, 32'h0);
    endtask

    task automatic t_busy_nowait();
        card_busy = 1'b1;
        launch_ready = 1'b0;
        for (int k = 0; k < SYNC + 1; k++) step();
        wr_cmd(32'h8000_0011);
        chk("R8 not held by busy", {31'h0, launch_valid}, 32'h1);
        launch_ready = 1'b1;
        step();
        launch_ready = 1'b0;
        chk("R8 start cleared", {31'h0, cmd_rdata[31]}, 32'h0);
        card_busy = 1'b0;
        for (int k = 0; k < SYNC + 1; k++) step();
    endtask

    task automatic t_clk_update();
        launch_ready = 1'b1;
        wr_cmd(32'h8020_0000);
        for (int k = 1; k <= UPD; k++) begin
            chk("R9 no bus launch", {31'h0, launch_valid}, 32'h0);
            chk("R9 apply timing", {31'h0, clk_apply}, {31'h0, k == UPD});
            chk("R9 start set", {31'h0, cmd_rdata[31]}, 32'h1);
            step();
        end
        chk("R9 start cleared", cmd_rdata, 32'h0020_0000);
        chk("R9 single pulse", {31'h0, clk_apply}, 32'h0);
        launch_ready = 1'b0;
    endtask

    task automatic t_clk_update_busy();
        card_busy = 1'b1;
        for (int k = 0; k < SYNC + 1; k++) step();
        wr_cmd(32'h8020_2000);
        for (int k = 0; k < 5; k++) begin
            chk("R10 held while busy", {31'h0, clk_apply}, 32'h0);
            step();
        end
        card_busy = 1'b0;
        for (int k = 1; k <= SYNC + UPD - 1; k++) begin
            step();
            chk("R10 apply after release", {31'h0, clk_apply},
                {31'h0, k == SYNC + UPD - 1});
            chk("R10 no bus launch", {31'h0, launch_valid}, 32'h0);
        end
        step();
        chk("R10 start cleared", {31'h0, cmd_rdata[31]}, 32'h0);
    endtask

    initial begin
        for (int k = 0; k < 3; k++) @(negedge clk);
        rst = 1'b0;
        step();
        t_reset();
        t_decode(32'h7FFF_FFFF);
        t_decode(32'h0000_1751);
        t_decode(32'h0000_A880);
        t_bus_launch();
        t_ignore();
        t_busy_wait();
        t_busy_nowait();
        t_clk_update();
        t_clk_update_busy();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule